// File: doc/BRIEF.md
# USB Debug Port Transaction Scheduler

This block decides when a USB debug port is allowed to use the bus. It derives a one-microsecond tick from the core clock. From that tick it runs two periodic counters. The poll counter sets how often a pending software debug request is sampled. The keepalive counter paces standalone 32-bit SYNC keepalives, and it runs only while the host controller is stopped. Once the host controller is running, SOF traffic keeps the attached device awake, so the block sends nothing of its own.

A port reset or a suspend/resume sequence sets a hold-off flag. The flag blocks debug grants and is cleared only by the first SOF strobe that arrives after both reset and suspend have dropped. The debug enable input has no tie to the port enable bit of the port status/control register. A grant makes the block busy until the transaction reports done. No keepalive can start while the block is busy, and the keepalive interval starts again from zero when the transaction finishes. The block also holds the device address and endpoint number that every generated token uses. Both can be changed through a small write port.

Top module: `usb_dbg_sched`

## Requirements
- R1: After reset, tok_addr_o is 7'h7F, tok_ep_o is 4'h1, and grant_o, ka_o and busy_o are all 0.
- R2: When cfg_we_i is high at a clock edge, tok_addr_o takes cfg_addr_i and tok_ep_o takes cfg_ep_i from that edge on. With cfg_we_i low, both outputs keep their values.
- R3: While run_i is 0 and the block is not busy, ka_o gives a one-cycle pulse once every KA_US microsecond ticks, which is KA_US*TICK_DIV clocks. The default of 1000 µs stays under 2 ms.
- R4: While run_i is 1, ka_o stays 0. The keepalive count is held at zero during this time.
- R5: go_i is sampled only on poll strobes, which come every POLL_US ticks (default 125). grant_o is a one-cycle pulse in the cycle after a strobe at which the grant conditions held.
- R6: grant_o stays 0 whenever en_i was 0 at the poll strobe. en_i is a separate input and does not follow any port enable bit.
- R7: A high port_rst_i or suspend_i sets hold-off, and no grant is given while it is set. Hold-off clears only on the first sof_i pulse that arrives while both port_rst_i and suspend_i are low.
- R8: busy_o rises in the same cycle as grant_o and falls in the cycle after done_i. While busy_o is high, no grant and no keepalive occurs.
- R9: The keepalive count is held at zero while busy. The first keepalive after done_i therefore comes a full KA_US ticks later.
- R10: When a keepalive and a poll strobe fall on the same tick, the keepalive is issued and no grant is given for that poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Host controller run state (1 = running) |
| port_rst_i | input | 1 | Port is being reset |
| suspend_i | input | 1 | Port is in a suspend/resume sequence |
| sof_i | input | 1 | One-cycle strobe: an SOF was sent |
| en_i | input | 1 | Debug port enabled by the debug driver |
| go_i | input | 1 | Software debug request pending |
| done_i | input | 1 | Granted transaction finished |
| cfg_we_i | input | 1 | Write strobe for address and endpoint |
| cfg_addr_i | input | 7 | New device address |
| cfg_ep_i | input | 4 | New endpoint number |
| ka_o | output | 1 | One-cycle request to send a standalone SYNC keepalive |
| grant_o | output | 1 | One-cycle grant of a debug transaction |
| busy_o | output | 1 | A granted transaction is in progress |
| tok_addr_o | output | 7 | Device address used for tokens |
| tok_ep_o | output | 4 | Endpoint used for tokens |

## Verification
Some rules are checked on every cycle by the assertions. These are: no keepalive while running or busy, no grant while busy, while disabled or while reset/suspend is high, a keepalive always beats a grant, and busy always accompanies a grant. Other behaviour only shows in the bench scenarios, because it depends on counting over time: the exact keepalive spacing, hold-off persisting past the end of reset until an SOF arrives, the keepalive timer restarting after done, and grants lining up with the poll period.

// File: rtl/usb_dbg_pkg.sv
package usb_dbg_pkg;
  localparam int ADDR_W = 7;
  localparam int EP_W   = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [EP_W-1:0]   ep;
  } tok_cfg_t;

  localparam tok_cfg_t TOK_CFG_RST = '{addr: 7'h7F, ep: 4'h1};
endpackage

// File: rtl/dbg_us_tick.sv
module dbg_us_tick #(
  parameter int TICK_DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

  logic [W-1:0] div_q;

  assign tick_o = (div_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/dbg_period_ctr.sv
module dbg_period_ctr #(
  parameter int PERIOD = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic hit_o
);
  localparam int W = $clog2(PERIOD + 1);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  assign hit_o = tick_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || hit_o) cnt_q <= '0;
    else if (tick_i)         cnt_q <= cnt_q + 1'b1;
  end

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r9_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/dbg_holdoff.sv
module dbg_holdoff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic port_rst_i,
  input  logic suspend_i,
  input  logic sof_i,
  output logic hold_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hold_q <= 1'b0;
    else if (port_rst_i || suspend_i) hold_q <= 1'b1;
    else if (sof_i)                  hold_q <= 1'b0;
  end

  // live inputs cover the cycle before the flag registers
  assign hold_o = hold_q || port_rst_i || suspend_i;

  a_r7_hold_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !sof_i) |=> hold_o);
endmodule

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
  import usb_dbg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [EP_W-1:0]   ep_i,
  output tok_cfg_t          cfg_o
);
  tok_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= TOK_CFG_RST;
    else if (we_i) cfg_q <= '{addr: addr_i, ep: ep_i};
  end

  assign cfg_o = cfg_q;

  a_r2_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/usb_dbg_sched.sv
module usb_dbg_sched
  import usb_dbg_pkg::*;
#(
  parameter int TICK_DIV = 50,
  parameter int KA_US    = 1000,
  parameter int POLL_US  = 125
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              port_rst_i,
  input  logic              suspend_i,
  input  logic              sof_i,
  input  logic              en_i,
  input  logic              go_i,
  input  logic              done_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [EP_W-1:0]   cfg_ep_i,
  output logic              ka_o,
  output logic              grant_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] tok_addr_o,
  output logic [EP_W-1:0]   tok_ep_o
);
  logic     tick, poll_hit, ka_hit, hold, ka_clr, grant_d;
  logic     ka_q, grant_q, busy_q;
  tok_cfg_t cfg;

  dbg_us_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  dbg_period_ctr #(.PERIOD(POLL_US)) u_poll (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .clr_i(1'b0), .hit_o(poll_hit)
  );

  // keepalive only in stopped mode and never while a transaction runs
  assign ka_clr = run_i || busy_q;

  dbg_period_ctr #(.PERIOD(KA_US)) u_ka (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .clr_i(ka_clr), .hit_o(ka_hit)
  );

  dbg_holdoff u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .port_rst_i(port_rst_i),
    .suspend_i(suspend_i), .sof_i(sof_i), .hold_o(hold)
  );

  dbg_cfg_regs u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .addr_i(cfg_addr_i), .ep_i(cfg_ep_i), .cfg_o(cfg)
  );

  assign grant_d = poll_hit && go_i && en_i && !hold && !busy_q && !ka_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ka_q    <= 1'b0;
      grant_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      ka_q    <= ka_hit;
      grant_q <= grant_d;
      if (grant_d)     busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
    end
  end

  assign ka_o       = ka_q;
  assign grant_o    = grant_q;
  assign busy_o     = busy_q;
  assign tok_addr_o = cfg.addr;
  assign tok_ep_o   = cfg.ep;

  a_r4_no_ka_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> !ka_o);
  a_r8_no_ka_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !ka_o);
  a_r8_no_grant_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !grant_o);
  a_r8_busy_with_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> busy_o);
  a_r8_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_i) |=> busy_o);
  a_r6_no_grant_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !grant_o);
  a_r7_no_grant_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_rst_i || suspend_i) |=> !grant_o);
  a_r10_ka_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ka_o |-> !grant_o);
  a_r5_grant_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o);
endmodule

// File: tb/usb_dbg_sched_tb.sv
module usb_dbg_sched_tb;
  localparam int TD = 4;
  localparam int KU = 30;
  localparam int PU = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, prst = 0, susp = 0, sof = 0, en = 0, go = 0, done = 0, we = 0;
  logic [6:0] waddr = '0;
  logic [3:0] wep = '0;
  logic ka, grant, busy;
  logic [6:0] taddr;
  logic [3:0] tep;

  int n_chk = 0, n_bad = 0;
  bit model_on = 0;

  always #10 clk = ~clk;

  usb_dbg_sched #(.TICK_DIV(TD), .KA_US(KU), .POLL_US(PU)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .port_rst_i(prst), .suspend_i(susp),
    .sof_i(sof), .en_i(en), .go_i(go), .done_i(done), .cfg_we_i(we),
    .cfg_addr_i(waddr), .cfg_ep_i(wep), .ka_o(ka), .grant_o(grant), .busy_o(busy),
    .tok_addr_o(taddr), .tok_ep_o(tep)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  int m_div, m_poll, m_ka;
  bit m_busy, m_hold, e_ka, e_grant;
  logic [6:0] m_addr;
  logic [3:0] m_ep;

  function automatic bit next_tick(int d); return d == TD - 1; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_poll = 0; m_ka = 0; m_busy = 0; m_hold = 0;
      e_ka = 0; e_grant = 0; m_addr = 7'h7F; m_ep = 4'h1;
    end else begin
      bit t, ph, kh, kc, g;
      t  = next_tick(m_div);
      ph = t && (m_poll == PU - 1);
      kc = run || m_busy;
      kh = t && !kc && (m_ka == KU - 1);
      g  = ph && go && en && !(m_hold || prst || susp) && !m_busy && !kh;
      m_div  = t ? 0 : m_div + 1;
      if (t) m_poll = ph ? 0 : m_poll + 1;
      if (kc || kh) m_ka = 0; else if (t) m_ka = m_ka + 1;
      e_ka = kh; e_grant = g;
      if (g) m_busy = 1; else if (done) m_busy = 0;
      if (prst || susp) m_hold = 1; else if (sof) m_hold = 0;
      if (we) begin m_addr = waddr; m_ep = wep; end
    end
  end

  always @(negedge clk) if (model_on && rst_n) begin
    check("R3/R4/R9/R10 ka", ka, e_ka);
    check("R5/R6/R7 grant", grant, e_grant);
    check("R8 busy", busy, m_busy);
    check("R2 addr", taddr, m_addr);
    check("R2 ep", tep, m_ep);
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 addr", taddr, 7'h7F);
    check("R1 ep", tep, 4'h1);
    check("R1 grant", grant, 0);
    check("R1 ka", ka, 0);
    check("R1 busy", busy, 0);
    model_on = 1;

    // R2 directed write
    we = 1; waddr = 7'h15; wep = 4'h9;
    @(negedge clk); we = 0; waddr = 7'h00; wep = 4'h0;
    cyc(2);
    check("R2 addr direct", taddr, 7'h15);
    check("R2 ep direct", tep, 4'h9);

    // R3 keepalive spacing in stopped mode
    begin
      int gap = 0;
      run = 0; en = 0; go = 0;
      while (!ka) @(negedge clk);
      @(negedge clk);
      while (!ka) begin gap++; @(negedge clk); end
      check("R3 ka spacing", gap + 1, KU * TD);
    end

    // R4 none while running
    begin
      int kas = 0;
      run = 1;
      for (int i = 0; i < 3 * KU * TD; i++) begin @(negedge clk); if (ka) kas++; end
      check("R4 ka while running", kas, 0);
    end

    // R7 hold-off after port reset until SOF
    begin
      int gr = 0;
      en = 1; go = 1; prst = 1;
      cyc(5); prst = 0;
      for (int i = 0; i < 4 * PU * TD; i++) begin @(negedge clk); if (grant) gr++; end
      check("R7 held after reset", gr, 0);
      sof = 1; @(negedge clk); sof = 0;
      gr = 0;
      for (int i = 0; i < PU * TD + 2; i++) begin @(negedge clk); if (grant) gr++; end
      check("R7 grant after sof", gr, 1);
      // R8 busy blocks further grants
      gr = 0;
      for (int i = 0; i < 3 * PU * TD; i++) begin @(negedge clk); if (grant) gr++; end
      check("R8 no grant while busy", gr, 0);
      check("R8 busy held", busy, 1);
      done = 1; @(negedge clk); done = 0; @(negedge clk);
      check("R8 busy clears", busy, 0);
    end

    // R9 keepalive timer restarts after done
    begin
      int gap = 0;
      go = 0; run = 0;
      while (!ka) begin gap++; @(negedge clk); end
      check("R9 first ka after done", (gap <= KU * TD) ? 1 : 0, 1);
    end

    // R6 disabled: suspend path too
    begin
      int gr = 0;
      en = 0; go = 1; susp = 1; cyc(3); susp = 0; sof = 1; @(negedge clk); sof = 0;
      for (int i = 0; i < 3 * PU * TD; i++) begin @(negedge clk); if (grant) gr++; end
      check("R6 no grant disabled", gr, 0);
    end

    // constrained random against the model
    for (int i = 0; i < 40000; i++) begin
      if ($urandom_range(0, 499) == 0) run = ~run;
      prst = ($urandom_range(0, 799) == 0) ? 1'b1 : (prst && $urandom_range(0, 3) != 0);
      susp = ($urandom_range(0, 999) == 0) ? 1'b1 : (susp && $urandom_range(0, 7) != 0);
      sof  = ($urandom_range(0, 59) == 0);
      en   = ($urandom_range(0, 9) != 0);
      go   = ($urandom_range(0, 2) != 0);
      done = busy && ($urandom_range(0, 19) == 0);
      we   = ($urandom_range(0, 299) == 0);
      waddr = 7'($urandom); wep = 4'($urandom);
      @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule